// File: doc/BRIEF.md
# PCI Initiator Handshake Sequencer

This block runs the initiator side of a conventional parallel PCI-style bus for transfers of one data phase. A local agent hands it a request: address, command, direction and write data. The block then raises its bus request and waits for a grant while the bus is idle. It runs one address phase and one data phase, and sends back a single-cycle response. The response carries a status code and, for reads, the captured data.

On the bus side the block drives REQ#, FRAME#, IRDY#, AD, C/BE# and PAR. Each of these comes out as a value together with an output enable, so the pads can be built outside the block. The block samples the target's DEVSEL#, TRDY# and STOP#, and it also samples the shared FRAME# and IRDY# lines. Before it lets go of a sustained tri-state line, it drives that line high for one clock. It keeps a minimum gap between two assertions of REQ#. When the bus is idle and the grant is its own, it parks the AD, C/BE# and PAR lines at valid levels. An active-low reset releases every bus output at once, without waiting for a clock.

Top module: `pci_init_seq`

## Requirements
- R1: The block samples DEVSEL# at each rising edge from the first edge after FRAME# goes low. If DEVSEL# is not sampled low at any of the first DEVSEL_LIMIT edges (default 5), the transaction ends with status MASTER_ABORT (code 2).
- R2: If STOP# is sampled low during the data phase, the transaction ends with status RETRY (code 1). STOP# wins over a TRDY# that is sampled low at the same edge.
- R3: The data phase completes with status OK (code 0) at the edge where TRDY# and DEVSEL# are both sampled low. On a read, rspRdata_o returns the AD value sampled at that edge. Until then, IRDY# stays driven low.
- R4: FRAME# and IRDY# are each driven high, with their enable on, for exactly one cycle before their enable drops. FRAME# is driven high during the first data-phase cycle. IRDY# is driven high in the cycle after the data phase ends.
- R5: After REQ# goes high, it stays high for at least REQ_GAP (default 2) cycles before it goes low again.
- R6: PAR is the even parity over AD and C/BE#, that is the XOR of all their bits. It is driven one clock after the lines it covers, and only when the block drove AD in that earlier cycle.
- R7: When the block is not in a transaction, GNT# is sampled low, and FRAME# and IRDY# are sampled high, it drives AD and C/BE# to all zeros in the next cycle. When GNT# is sampled high, it releases them in the next cycle.
- R8: The address phase starts only after an edge where REQ# is low, GNT# is sampled low, and FRAME# and IRDY# are sampled high. FRAME# is then low for exactly one cycle, with the address on AD and the command on C/BE#. In the data phase, C/BE# is all zeros, meaning all bytes are enabled. AD carries the write data on a write and is released on a read.
- R9: While rstN is low, all output enables (REQ#, FRAME#, IRDY#, AD, C/BE#, PAR) and rspValid_o are low, with no clock needed.
- R10: reqReady_o is high only while the block is idle. Each accepted request produces exactly one rspValid_o pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid_i | input | 1 | Local request valid |
| reqReady_o | output | 1 | Block idle, request accepted when valid |
| reqAddr_i | input | BUS_W | Transfer address |
| reqCmd_i | input | CBE_W | Bus command |
| reqWrite_i | input | 1 | 1 = write, 0 = read |
| reqWdata_i | input | BUS_W | Write data |
| rspValid_o | output | 1 | Response pulse |
| rspStatus_o | output | 2 | 0 OK, 1 RETRY, 2 MASTER_ABORT |
| rspRdata_o | output | BUS_W | Read data captured on completion |
| reqN_o | output | 1 | REQ# value |
| reqOe_o | output | 1 | REQ# enable |
| gntN_i | input | 1 | GNT# |
| frameN_o | output | 1 | FRAME# value |
| frameOe_o | output | 1 | FRAME# enable |
| frameN_i | input | 1 | FRAME# as seen on the bus |
| irdyN_o | output | 1 | IRDY# value |
| irdyOe_o | output | 1 | IRDY# enable |
| irdyN_i | input | 1 | IRDY# as seen on the bus |
| devselN_i | input | 1 | DEVSEL# from target |
| trdyN_i | input | 1 | TRDY# from target |
| stopN_i | input | 1 | STOP# from target |
| adOut_o | output | BUS_W | AD value |
| adOe_o | output | 1 | AD enable |
| adIn_i | input | BUS_W | AD as seen on the bus |
| cbeOut_o | output | CBE_W | C/BE# value |
| cbeOe_o | output | 1 | C/BE# enable |
| par_o | output | 1 | PAR value |
| parOe_o | output | 1 | PAR enable |

## Verification
A bad state register would show up within one clock at the FRAME#/IRDY# enables or the AD lines. Examples are an address phase longer than one cycle, a data phase that never starts, or an enable that drops without the one high cycle first. A wrong DEVSEL# window counter or a lost sticky flag appears as a wrong status code. The bench steps the DEVSEL# delay across the window edge, so an off-by-one gives MASTER_ABORT where OK is expected, or the reverse, on that same transaction. A wrong REQ# gap counter shows up the next time REQ# goes low. A wrong parity pipeline shows up one cycle after any driven AD phase.

// File: rtl/pci_seq_pkg.sv
package pci_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } seqState_t;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_RETRY  = 2'd1,
    RSP_MABORT = 2'd2
  } rspCode_t;

  // strobes from control to datapath, acting at the coming edge
  typedef struct packed {
    logic latchReq;
    logic drvAddr;
    logic drvData;
    logic drvPark;
    logic capture;
  } dpCtl_t;

endpackage

// File: rtl/pci_seq_dp.sv
module pci_seq_dp
  import pci_seq_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CBE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl_i,
  input  logic [BUS_W-1:0] reqAddr_i,
  input  logic [CBE_W-1:0] reqCmd_i,
  input  logic             reqWrite_i,
  input  logic [BUS_W-1:0] reqWdata_i,
  input  logic [BUS_W-1:0] adIn_i,
  output logic [BUS_W-1:0] adOut_o,
  output logic             adOe_o,
  output logic [CBE_W-1:0] cbeOut_o,
  output logic             cbeOe_o,
  output logic             par_o,
  output logic             parOe_o,
  output logic [BUS_W-1:0] rspRdata_o
);

  logic [BUS_W-1:0] addrQ;
  logic [BUS_W-1:0] wdataQ;
  logic [CBE_W-1:0] cmdQ;
  logic             writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      cmdQ   <= '0;
      writeQ <= 1'b0;
    end else if (dpCtl_i.latchReq) begin
      addrQ  <= reqAddr_i;
      wdataQ <= reqWdata_i;
      cmdQ   <= reqCmd_i;
      writeQ <= reqWrite_i;
    end
  end

  // AD / C/BE# drive selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adOut_o  <= '0;
      adOe_o   <= 1'b0;
      cbeOut_o <= '0;
      cbeOe_o  <= 1'b0;
    end else if (dpCtl_i.drvAddr) begin
      adOut_o  <= addrQ;
      adOe_o   <= 1'b1;
      cbeOut_o <= cmdQ;
      cbeOe_o  <= 1'b1;
    end else if (dpCtl_i.drvData) begin
      adOut_o  <= writeQ ? wdataQ : '0;
      adOe_o   <= writeQ;
      cbeOut_o <= '0;
      cbeOe_o  <= 1'b1;
    end else if (dpCtl_i.drvPark) begin
      adOut_o  <= '0;
      adOe_o   <= 1'b1;
      cbeOut_o <= '0;
      cbeOe_o  <= 1'b1;
    end else begin
      adOe_o   <= 1'b0;
      cbeOe_o  <= 1'b0;
    end
  end

  // parity trails the lines it covers by one clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      par_o   <= 1'b0;
      parOe_o <= 1'b0;
    end else begin
      par_o   <= ^{adOut_o, cbeOut_o};
      parOe_o <= adOe_o;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata_o <= '0;
    end else if (dpCtl_i.capture && !writeQ) begin
      rspRdata_o <= adIn_i;
    end
  end

  AST_PAR_ENABLE_LAG: assert property (@(posedge clk) disable iff (!rstN)
    parOe_o |-> $past(adOe_o)); // R6
  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe_o |-> (par_o == ^{$past(adOut_o), $past(cbeOut_o)})); // R6
  AST_ONE_DRIVER_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({dpCtl_i.drvAddr, dpCtl_i.drvData, dpCtl_i.drvPark}) <= 1); // R8

endmodule

// File: rtl/pci_seq_ctrl.sv
module pci_seq_ctrl
  import pci_seq_pkg::*;
#(
  parameter int DEVSEL_LIMIT = 5,
  parameter int REQ_GAP      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid_i,
  output logic       reqReady_o,
  input  logic       gntN_i,
  input  logic       frameN_i,
  input  logic       irdyN_i,
  input  logic       devselN_i,
  input  logic       trdyN_i,
  input  logic       stopN_i,
  output logic       reqN_o,
  output logic       reqOe_o,
  output logic       frameN_o,
  output logic       frameOe_o,
  output logic       irdyN_o,
  output logic       irdyOe_o,
  output logic       rspValid_o,
  output logic [1:0] rspStatus_o,
  output dpCtl_t     dpCtl_o
);

  localparam int WAIT_W = $clog2(DEVSEL_LIMIT + 1);
  localparam int GAP_W  = $clog2(REQ_GAP + 1);

  seqState_t          state, stateNext;
  logic [WAIT_W-1:0]  waitCnt;
  logic               devselSeen;
  logic [GAP_W-1:0]   gapCnt;

  logic busIdle, gntSeen, gapOk, startNow, devselNow;
  logic abortNow, stopNow, doneNow, endNow;

  assign busIdle   = frameN_i && irdyN_i;
  assign gntSeen   = !gntN_i;
  assign gapOk     = (int'(gapCnt) + 1) >= REQ_GAP;
  assign startNow  = (state == ST_WAIT) && !reqN_o && gntSeen && busIdle;
  assign devselNow = devselSeen || !devselN_i;
  assign abortNow  = (state == ST_DATA) && !devselNow
                     && (waitCnt == WAIT_W'(DEVSEL_LIMIT - 1));
  assign stopNow   = (state == ST_DATA) && !stopN_i && !abortNow;
  assign doneNow   = (state == ST_DATA) && !trdyN_i && !devselN_i
                     && stopN_i && !abortNow;
  assign endNow    = abortNow || stopNow || doneNow;

  assign reqReady_o = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    dpCtl_o   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid_i) begin
          stateNext        = ST_WAIT;
          dpCtl_o.latchReq = 1'b1;
        end
        if (gntSeen && busIdle) dpCtl_o.drvPark = 1'b1;
      end
      ST_WAIT: begin
        if (startNow) begin
          stateNext       = ST_ADDR;
          dpCtl_o.drvAddr = 1'b1;
        end else if (gntSeen && busIdle) begin
          dpCtl_o.drvPark = 1'b1;
        end
      end
      ST_ADDR: begin
        stateNext       = ST_DATA;
        dpCtl_o.drvData = 1'b1;
      end
      ST_DATA: begin
        if (endNow) begin
          stateNext       = ST_TURN;
          dpCtl_o.capture = doneNow;
        end else begin
          dpCtl_o.drvData = 1'b1;
        end
      end
      ST_TURN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      reqN_o      <= 1'b1;
      reqOe_o     <= 1'b0;
      frameN_o    <= 1'b1;
      frameOe_o   <= 1'b0;
      irdyN_o     <= 1'b1;
      irdyOe_o    <= 1'b0;
      rspValid_o  <= 1'b0;
      rspStatus_o <= RSP_OK;
      waitCnt     <= '0;
      devselSeen  <= 1'b0;
      gapCnt      <= GAP_W'(REQ_GAP);
    end else begin
      state     <= stateNext;
      reqOe_o   <= 1'b1;
      reqN_o    <= !((state == ST_WAIT) && !startNow && (!reqN_o || gapOk));
      if (reqN_o) begin
        if (int'(gapCnt) < REQ_GAP) gapCnt <= gapCnt + 1'b1;
      end else begin
        gapCnt <= '0;
      end
      frameN_o  <= (stateNext != ST_ADDR);
      frameOe_o <= (stateNext == ST_ADDR) || (state == ST_ADDR);
      irdyN_o   <= (stateNext != ST_DATA);
      irdyOe_o  <= (stateNext == ST_DATA) || (stateNext == ST_TURN);
      if (state == ST_ADDR) begin
        waitCnt    <= WAIT_W'(1);
        devselSeen <= !devselN_i;
      end else if (state == ST_DATA) begin
        if (int'(waitCnt) < DEVSEL_LIMIT) waitCnt <= waitCnt + 1'b1;
        devselSeen <= devselNow;
      end else begin
        waitCnt    <= '0;
        devselSeen <= 1'b0;
      end
      rspValid_o <= endNow;
      if (endNow) begin
        rspStatus_o <= abortNow ? RSP_MABORT : (stopNow ? RSP_RETRY : RSP_OK);
      end
    end
  end

  AST_MABORT_NO_DEVSEL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid_o && rspStatus_o == RSP_MABORT) |-> $past(devselN_i)); // R1
  AST_STOP_IS_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !stopN_i && devselNow) |=> (rspValid_o && rspStatus_o == RSP_RETRY)); // R2
  AST_IRDY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOe_o && !irdyN_o && trdyN_i && stopN_i && !abortNow) |=> (irdyOe_o && !irdyN_o)); // R3
  AST_FRAME_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOe_o) |-> $past(frameN_o)); // R4
  AST_IRDY_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irdyOe_o) |-> $past(irdyN_o)); // R4
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqN_o) |-> $past(reqN_o, 2)); // R5
  AST_START_ON_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN_o) |-> $past(!gntN_i && frameN_i && irdyN_i && !reqN_o)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid_o |=> !rspValid_o); // R10

endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
  import pci_seq_pkg::*;
#(
  parameter int BUS_W        = 32,
  parameter int CBE_W        = BUS_W / 8,
  parameter int DEVSEL_LIMIT = 5,
  parameter int REQ_GAP      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid_i,
  output logic             reqReady_o,
  input  logic [BUS_W-1:0] reqAddr_i,
  input  logic [CBE_W-1:0] reqCmd_i,
  input  logic             reqWrite_i,
  input  logic [BUS_W-1:0] reqWdata_i,
  output logic             rspValid_o,
  output logic [1:0]       rspStatus_o,
  output logic [BUS_W-1:0] rspRdata_o,
  output logic             reqN_o,
  output logic             reqOe_o,
  input  logic             gntN_i,
  output logic             frameN_o,
  output logic             frameOe_o,
  input  logic             frameN_i,
  output logic             irdyN_o,
  output logic             irdyOe_o,
  input  logic             irdyN_i,
  input  logic             devselN_i,
  input  logic             trdyN_i,
  input  logic             stopN_i,
  output logic [BUS_W-1:0] adOut_o,
  output logic             adOe_o,
  input  logic [BUS_W-1:0] adIn_i,
  output logic [CBE_W-1:0] cbeOut_o,
  output logic             cbeOe_o,
  output logic             par_o,
  output logic             parOe_o
);

  dpCtl_t dpCtl;

  pci_seq_ctrl #(
    .DEVSEL_LIMIT (DEVSEL_LIMIT),
    .REQ_GAP      (REQ_GAP)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid_i  (reqValid_i),
    .reqReady_o  (reqReady_o),
    .gntN_i      (gntN_i),
    .frameN_i    (frameN_i),
    .irdyN_i     (irdyN_i),
    .devselN_i   (devselN_i),
    .trdyN_i     (trdyN_i),
    .stopN_i     (stopN_i),
    .reqN_o      (reqN_o),
    .reqOe_o     (reqOe_o),
    .frameN_o    (frameN_o),
    .frameOe_o   (frameOe_o),
    .irdyN_o     (irdyN_o),
    .irdyOe_o    (irdyOe_o),
    .rspValid_o  (rspValid_o),
    .rspStatus_o (rspStatus_o),
    .dpCtl_o     (dpCtl)
  );

  pci_seq_dp #(
    .BUS_W (BUS_W),
    .CBE_W (CBE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl_i    (dpCtl),
    .reqAddr_i  (reqAddr_i),
    .reqCmd_i   (reqCmd_i),
    .reqWrite_i (reqWrite_i),
    .reqWdata_i (reqWdata_i),
    .adIn_i     (adIn_i),
    .adOut_o    (adOut_o),
    .adOe_o     (adOe_o),
    .cbeOut_o   (cbeOut_o),
    .cbeOe_o    (cbeOe_o),
    .par_o      (par_o),
    .parOe_o    (parOe_o),
    .rspRdata_o (rspRdata_o)
  );

  AST_RESET_RELEASES_BUS: assert property (@(posedge clk)
    !rstN |-> !(reqOe_o || frameOe_o || irdyOe_o || adOe_o || cbeOe_o || parOe_o)); // R9

endmodule

// File: tb/pci_init_seq_tb_top.sv
`timescale 1ns/1ps
module pci_init_seq_tb_top;

  localparam int BW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [BW-1:0] reqAddr = '0;
  logic [CW-1:0] reqCmd = '0;
  logic          reqWrite = 1'b0;
  logic [BW-1:0] reqWdata = '0;
  logic          gntN = 1'b1;
  logic          otherBusy = 1'b0;
  logic          devselN = 1'b1;
  logic          trdyN = 1'b1;
  logic          stopN = 1'b1;
  logic [BW-1:0] tgtAd = '0;

  logic          reqReady, rspValid, reqN, reqOe, frameN, frameOe, irdyN, irdyOe;
  logic          adOe, cbeOe, par, parOe;
  logic [1:0]    rspStatus;
  logic [BW-1:0] rspRdata, adOut;
  logic [CW-1:0] cbeOut;
  logic          frameBus, irdyBus;
  logic [BW-1:0] adBus;

  assign frameBus = otherBusy ? 1'b0 : (frameOe ? frameN : 1'b1);
  assign irdyBus  = irdyOe ? irdyN : 1'b1;
  assign adBus    = adOe ? adOut : tgtAd;

  always #2 clk = ~clk;

  pci_init_seq dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid_i(reqValid), .reqReady_o(reqReady), .reqAddr_i(reqAddr),
    .reqCmd_i(reqCmd), .reqWrite_i(reqWrite), .reqWdata_i(reqWdata),
    .rspValid_o(rspValid), .rspStatus_o(rspStatus), .rspRdata_o(rspRdata),
    .reqN_o(reqN), .reqOe_o(reqOe), .gntN_i(gntN),
    .frameN_o(frameN), .frameOe_o(frameOe), .frameN_i(frameBus),
    .irdyN_o(irdyN), .irdyOe_o(irdyOe), .irdyN_i(irdyBus),
    .devselN_i(devselN), .trdyN_i(trdyN), .stopN_i(stopN),
    .adOut_o(adOut), .adOe_o(adOe), .adIn_i(adBus),
    .cbeOut_o(cbeOut), .cbeOe_o(cbeOe), .par_o(par), .parOe_o(parOe)
  );

  int checks = 0;
  int errors = 0;
  int gapChecks = 0;
  int gapErrors = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expStatus(input int devDly, input int mode);
    if (devDly >= 5) return 2'd2;
    if (mode != 0) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic expParity(input logic [BW-1:0] a, input logic [CW-1:0] c);
    return ^{a, c};
  endfunction

  // R5 monitor: REQ# high run length before each fall
  int highRun = 2;
  always @(negedge clk) begin
    if (!rstN) begin
      highRun = 2;
    end else if (reqN) begin
      highRun++;
    end else begin
      if (highRun > 0) begin
        gapChecks++;
        if (highRun < 2) begin
          gapErrors++;
          $display("FAIL R5 REQ# gap actual=%0d expected>=2", highRun);
        end
      end
      highRun = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors",
               checks + gapChecks + 1, errors + gapErrors + 1);
      $finish;
    end
  end

  task automatic issueReq(input logic wr, input logic [BW-1:0] a,
                          input logic [CW-1:0] c, input logic [BW-1:0] wd);
    for (int n = 0; n < 50 && !reqReady; n++) @(negedge clk);
    check(reqReady == 1'b1, "R10", "ready while idle", reqReady, 1);
    reqWrite = wr; reqAddr = a; reqCmd = c; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10", "ready drops when busy", reqReady, 0);
  endtask

  task automatic serviceTxn(input logic wr, input logic [BW-1:0] a,
                            input logic [CW-1:0] c, input logic [BW-1:0] wd,
                            input logic [BW-1:0] rd, input int devDly,
                            input int trdyDly, input int mode);
    logic [1:0] exp;
    bit got;
    exp = expStatus(devDly, mode);
    got = 0;
    for (int n = 0; n < 40 && !(frameOe && !frameN); n++) @(negedge clk);
    check(frameOe && !frameN, "R8", "FRAME# low", {frameOe, frameN}, 2'b10);
    check(adOe && adOut == a, "R8", "address on AD", adOut, a);
    check(cbeOe && cbeOut == c, "R8", "command on C/BE#", cbeOut, c);
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (rspValid) begin
        got = 1;
        break;
      end
      if (k == 1) begin
        check(parOe && par == expParity(a, c), "R6", "address parity", {parOe, par}, {1'b1, expParity(a, c)});
        check(frameOe && frameN, "R4", "FRAME# driven high", {frameOe, frameN}, 2'b11);
        check(irdyOe && !irdyN, "R3", "IRDY# low in data phase", {irdyOe, irdyN}, 2'b10);
        check(cbeOe && cbeOut == '0, "R8", "byte enables", cbeOut, 0);
        if (wr) check(adOe && adOut == wd, "R8", "write data on AD", adOut, wd);
        else    check(!adOe, "R8", "AD released on read", adOe, 0);
      end else if (k > 1) begin
        check(!frameOe, "R4", "FRAME# released", frameOe, 0);
        check(irdyOe && !irdyN, "R3", "IRDY# held low", {irdyOe, irdyN}, 2'b10);
      end
      if (devDly < 5 && k >= devDly) devselN = 1'b0;
      if (devDly < 5 && k >= devDly + trdyDly) begin
        if (mode != 1) trdyN = 1'b0;
        if (mode != 0) stopN = 1'b0;
        tgtAd = rd;
      end
    end
    check(got, "R10", "response seen", got, 1);
    check(rspStatus == exp, exp == 2'd2 ? "R1" : (exp == 2'd1 ? "R2" : "R3"),
          "status", rspStatus, exp);
    if (!wr && exp == 2'd0) check(rspRdata == rd, "R3", "read data", rspRdata, rd);
    check(irdyOe && irdyN, "R4", "IRDY# driven high", {irdyOe, irdyN}, 2'b11);
    devselN = 1'b1; trdyN = 1'b1; stopN = 1'b1;
    @(negedge clk);
    check(!irdyOe, "R4", "IRDY# released", irdyOe, 0);
    check(!rspValid, "R10", "single response pulse", rspValid, 0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(!(reqOe || frameOe || irdyOe || adOe || cbeOe || parOe), "R9", "enables in reset",
          {reqOe, frameOe, irdyOe, adOe, cbeOe, parOe}, 0);
    check(!rspValid, "R9", "no response in reset", rspValid, 0);
    rstN = 1'b1;

    // R7 parking
    gntN = 1'b0;
    @(negedge clk); @(negedge clk);
    check(adOe && adOut == '0 && cbeOe && cbeOut == '0, "R7", "parked lines",
          {adOe, cbeOe, adOut}, {2'b11, 32'h0});
    @(negedge clk);
    check(parOe && par == 1'b0, "R7", "parked parity", {parOe, par}, 2'b10);
    gntN = 1'b1;
    @(negedge clk);
    check(!adOe && !cbeOe, "R7", "park released without grant", {adOe, cbeOe}, 0);

    // R8 no start without grant, then with grant
    issueReq(1'b1, 32'h1000_0040, 4'h7, 32'hCAFE_F00D);
    repeat (5) begin
      @(negedge clk);
      check(!frameOe, "R8", "no FRAME# without grant", frameOe, 0);
    end
    check(!reqN, "R8", "REQ# asserted while waiting", reqN, 0);
    gntN = 1'b0;
    serviceTxn(1'b1, 32'h1000_0040, 4'h7, 32'hCAFE_F00D, '0, 1, 0, 0);

    // R8 no start while another master holds FRAME#
    otherBusy = 1'b1;
    issueReq(1'b0, 32'h2000_0000, 4'h6, '0);
    repeat (4) begin
      @(negedge clk);
      check(!frameOe, "R8", "no FRAME# on busy bus", frameOe, 0);
    end
    otherBusy = 1'b0;
    serviceTxn(1'b0, 32'h2000_0000, 4'h6, '0, 32'h1234_5678, 0, 0, 0);

    // R1 window edges
    issueReq(1'b0, 32'h3000_0004, 4'h6, '0);
    serviceTxn(1'b0, 32'h3000_0004, 4'h6, '0, 32'hA5A5_5A5A, 4, 1, 0);
    issueReq(1'b0, 32'h3000_0008, 4'h6, '0);
    serviceTxn(1'b0, 32'h3000_0008, 4'h6, '0, 32'h0, 5, 0, 0);

    // R2 STOP# with TRDY# together
    issueReq(1'b1, 32'h4000_0000, 4'h7, 32'h1111_2222);
    serviceTxn(1'b1, 32'h4000_0000, 4'h7, 32'h1111_2222, '0, 2, 0, 2);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic wr;
      logic [BW-1:0] a, wd, rd;
      logic [CW-1:0] c;
      int dd, td, sel, md;
      wr  = 1'($urandom_range(0, 1));
      a   = $urandom;
      wd  = $urandom;
      rd  = $urandom;
      c   = 4'($urandom_range(0, 15));
      dd  = $urandom_range(0, 6);
      td  = $urandom_range(0, 2);
      sel = $urandom_range(0, 5);
      md  = (sel < 4) ? 0 : sel - 3;
      issueReq(wr, a, c, wd);
      serviceTxn(wr, a, c, wd, rd, dd, td, md);
    end

    // R9 asynchronous reset in the middle of a transaction
    issueReq(1'b1, 32'h5000_0000, 4'h7, 32'hDEAD_BEEF);
    for (int n = 0; n < 20 && !(frameOe && !frameN); n++) @(negedge clk);
    @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    check(!(reqOe || frameOe || irdyOe || adOe || cbeOe || parOe), "R9", "async release",
          {reqOe, frameOe, irdyOe, adOe, cbeOe, parOe}, 0);
    @(negedge clk);
    rstN = 1'b1;
    issueReq(1'b0, 32'h6000_0010, 4'h6, '0);
    serviceTxn(1'b0, 32'h6000_0010, 4'h6, '0, 32'h7777_0001, 3, 2, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors",
             checks + gapChecks, errors + gapErrors);
    $finish;
  end

endmodule